// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register holding the directions of the most recently resolved branches. That global history picks one of several banks of 2-bit saturating counters, and the word-address bits of the branch PC pick the counter within the bank. Two branches whose outcomes are correlated can then train separate counters, depending on what happened just before them. The upper bit of the chosen counter is the prediction.

A front-end stage presents a PC on the predict port. One cycle later it receives the taken/not-taken guess and the history value used to form it. It keeps that history with the branch. When the branch resolves, a later stage presents the PC, the saved history and the real outcome on the update port. The counter chosen by that saved history is trained, and the outcome is shifted into the global history. The default geometry is a 2-bit history, so four banks, and 64 counters per bank.

Top module: `gh_dir_predictor`

## Requirements
- R1: After a synchronous reset, the history register is 00 and every counter holds the weakly not-taken code 01. Every PC is therefore predicted not-taken and reports history 00 until the first update.
- R2: A predict request in cycle t raises `pred_ready` for exactly cycle t+1, with `pred_taken` and `pred_hist` valid in that cycle. `pred_ready` is low in every cycle that does not follow a request.
- R3: The counter used for a prediction sits at bank = history register and entry = `pred_pc`, which carries PC bits IDX_W+1 down to 2. `pred_taken` is bit 1 of that counter (10 and 11 mean taken, 00 and 01 mean not-taken).
- R4: `pred_hist` returns the history register value that was current in the request cycle.
- R5: An update with `upd_taken`=1 raises the selected counter by one, and it holds at 11.
- R6: An update with `upd_taken`=0 lowers the selected counter by one, and it holds at 00.
- R7: An update trains the counter in bank `upd_hist`, entry `upd_pc`, whatever value the history register holds at the time.
- R8: Each update shifts `upd_taken` into history bit 0 (1 = taken), moves the older bits up one place and drops the oldest. With no update, the history holds.
- R9: When a predict and an update occur in the same cycle, the prediction sees the counter and the history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Predict request |
| pred_pc | input | IDX_W | PC bits IDX_W+1..2 of the branch to predict |
| pred_ready | output | 1 | Prediction result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction |
| upd_valid | input | 1 | Update request |
| upd_pc | input | IDX_W | PC bits IDX_W+1..2 of the resolved branch |
| upd_hist | input | HIST_W | History value returned with the branch's prediction |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions take it for granted that the valid inputs are never unknown, and that the PC, history and outcome fields are driven to known values whenever their valid is high. They do not assume that `upd_hist` matches the current history register or any earlier prediction. The stimulus keeps every input at a defined value in every cycle after reset, including idle ones. It deliberately sends update histories that differ from the live register, and it collides predicts with updates on the same entry in the same cycle.

// File: rtl/gh_pred_pkg.sv
package gh_pred_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'b00;
  localparam ctr2_t CTR_WEAK_NT   = 2'b01;
  localparam ctr2_t CTR_STRONG_T  = 2'b11;

  // saturating step of a 2-bit direction counter
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gh_history.sv
module gh_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_next;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_next = shift_bit;
    end else begin : g_multi
      assign hist_next = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= hist_next;
  end

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(shift_bit)); // R8

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q)); // R8

endmodule

// File: rtl/gh_counter_table.sv
module gh_counter_table
  import gh_pred_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [HIST_W+IDX_W-1:0]  rd_addr,
  output logic                     rd_valid,
  output ctr2_t                    rd_ctr,
  input  logic                     wr_en,
  input  logic [HIST_W+IDX_W-1:0]  wr_addr,
  input  logic                     wr_taken
);

  localparam int ADDR_W = HIST_W + IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;

  ctr2_t mem [DEPTH];
  ctr2_t wr_cur;

  assign wr_cur = mem[wr_addr];

  // counter storage: read-modify-write on update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_addr] <= ctr_step(wr_cur, wr_taken);
    end
  end

  // registered read port, returns the value before a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_ctr   <= CTR_WEAK_NT;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_ctr <= mem[rd_addr];
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R2

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R2

  AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur == CTR_STRONG_T) |=> mem[$past(wr_addr)] == CTR_STRONG_T); // R5

  AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur == CTR_STRONG_NT) |=> mem[$past(wr_addr)] == CTR_STRONG_NT); // R6

endmodule

// File: rtl/gh_dir_predictor.sv
module gh_dir_predictor
  import gh_pred_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid,
  input  logic [IDX_W+1:2]  pred_pc,
  output logic              pred_ready,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [IDX_W+1:2]  upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);

  localparam int ADDR_W = HIST_W + IDX_W;

  logic [HIST_W-1:0] hist_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  ctr2_t             rd_ctr;

  // bank from history in the upper address bits, entry from PC below
  assign rd_addr = {hist_q, pred_pc};
  assign wr_addr = {upd_hist, upd_pc};

  gh_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist_q    (hist_q)
  );

  gh_counter_table #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_valid),
    .rd_addr  (rd_addr),
    .rd_valid (pred_ready),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_addr  (wr_addr),
    .wr_taken (upd_taken)
  );

  always_ff @(posedge clk) begin
    if (rst)             pred_hist <= '0;
    else if (pred_valid) pred_hist <= hist_q;
  end

  assign pred_taken = rd_ctr[1];

  AST_PRED_HIST_ECHO: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_hist == $past(hist_q)); // R4

  AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (rst)
    pred_ready |-> !$isunknown(pred_taken)); // R3

endmodule

// File: tb/gh_dir_predictor_test.sv
module gh_dir_predictor_test;

  localparam int HW   = 2;
  localparam int IW   = 6;
  localparam int NENT = 1 << (HW + IW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          pred_valid = 1'b0;
  logic [IW-1:0] pred_pc    = '0;
  logic          pred_ready;
  logic          pred_taken;
  logic [HW-1:0] pred_hist;
  logic          upd_valid  = 1'b0;
  logic [IW-1:0] upd_pc     = '0;
  logic [HW-1:0] upd_hist   = '0;
  logic          upd_taken  = 1'b0;

  gh_dir_predictor #(.HIST_W(HW), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_ready(pred_ready), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
  );

  int checks = 0;
  int errors = 0;

  logic [1:0]    m_ctr [NENT];
  logic [HW-1:0] m_hist;
  logic [HW:0]   exp_q [$];
  string         tag_q [$];

  function automatic logic [1:0] model_step(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  // driver: one cycle of stimulus, expected result queued before model update (R9)
  task automatic cyc(bit dp, logic [IW-1:0] pp, bit du, logic [IW-1:0] up,
                     logic [HW-1:0] uh, bit ut, string tag);
    @(negedge clk);
    if (dp) begin
      exp_q.push_back({m_ctr[{m_hist, pp}][1], m_hist});
      tag_q.push_back(tag);
    end
    if (du) begin
      m_ctr[{uh, up}] = model_step(m_ctr[{uh, up}], ut);
      m_hist = {m_hist[HW-2:0], ut};
    end
    pred_valid = dp; pred_pc = pp;
    upd_valid = du;  upd_pc = up; upd_hist = uh; upd_taken = ut;
  endtask

  task automatic pred(logic [IW-1:0] pp, string tag);
    cyc(1, pp, 0, '0, '0, 0, tag);
  endtask

  task automatic upd(logic [IW-1:0] up, logic [HW-1:0] uh, bit ut, string tag);
    cyc(0, '0, 1, up, uh, ut, tag);
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, '0, 0, '0, '0, 0, "R2");
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (!rst && pred_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected pred_ready actual=1 expected=0");
      end else begin
        logic [HW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({pred_taken, pred_hist} !== e) begin
          errors++;
          $display("FAIL %s taken/hist actual=%b/%b expected=%b/%b",
                   t, pred_taken, pred_hist, e[HW], e[HW-1:0]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) m_ctr[i] = 2'b01;
    m_hist = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: idle after reset
    @(negedge clk);
    checks++;
    if (pred_ready !== 1'b0) begin
      errors++;
      $display("FAIL R2 pred_ready after reset actual=%b expected=0", pred_ready);
    end

    // R1: reset state
    pred(6'd0, "R1"); pred(6'd5, "R1"); pred(6'd63, "R1"); pred(6'd17, "R1");
    idle(2);

    // R5: three taken into bank 3, then read at history 11
    upd(6'd10, 2'd3, 1, "R5"); upd(6'd10, 2'd3, 1, "R5"); upd(6'd10, 2'd3, 1, "R5");
    pred(6'd10, "R5");
    upd(6'd10, 2'd3, 1, "R5");
    pred(6'd10, "R5");
    idle(1);

    // R6: three not-taken into bank 0, then recover with two taken
    upd(6'd20, 2'd0, 0, "R6"); upd(6'd20, 2'd0, 0, "R6"); upd(6'd20, 2'd0, 0, "R6");
    pred(6'd20, "R6");
    upd(6'd20, 2'd0, 1, "R6"); upd(6'd20, 2'd0, 1, "R6");
    upd(6'd50, 2'd2, 0, "R6"); upd(6'd50, 2'd2, 0, "R6");
    pred(6'd20, "R6");
    idle(1);

    // R7: train bank 2 while the live history differs
    upd(6'd30, 2'd2, 1, "R7"); upd(6'd30, 2'd2, 1, "R7");
    upd(6'd60, 2'd1, 1, "R7"); upd(6'd60, 2'd1, 0, "R7");
    pred(6'd30, "R7");
    pred(6'd60, "R7");
    idle(1);

    // R8 / R4: history follows an outcome pattern
    upd(6'd1, 2'd0, 1, "R8"); pred(6'd2, "R8");
    upd(6'd1, 2'd1, 0, "R8"); pred(6'd2, "R4");
    upd(6'd1, 2'd2, 0, "R8"); pred(6'd2, "R8");
    upd(6'd1, 2'd0, 1, "R8"); pred(6'd2, "R4");
    upd(6'd1, 2'd1, 1, "R8"); pred(6'd2, "R8");
    idle(1);

    // R9: predict and update on the same entry in one cycle
    cyc(1, 6'd12, 1, 6'd12, m_hist, 1, "R9");
    cyc(1, 6'd12, 1, 6'd12, m_hist, 1, "R9");
    pred(6'd12, "R9");
    idle(1);

    // R3: mixed traffic on a few colliding entries
    for (int n = 0; n < 400; n++) begin
      cyc($urandom_range(0, 1), 6'($urandom_range(0, 7)),
          $urandom_range(0, 1), 6'($urandom_range(0, 7)),
          HW'($urandom_range(0, 3)), $urandom_range(0, 1), "R3");
    end
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule